// File: doc/BRIEF.md
# USB Charger Detection Sequencer

This block runs the battery-charger detection handshake on a USB port. It watches a bus-power comparator, a data-line detect comparator and a DP-low comparator. It drives enable strobes for the analog DP voltage source, the DM current sink and the DP detection current source. It raises a detect flag when a charger has been recognised. Every analog element sits outside the block; here each one is only an enable or a flag.

Two handshakes can be selected. In the current-sink method, a delay follows the power debounce. The DP voltage source and the DM sink then run together while the data-detect flag is debounced. The detect flag rises a fixed time after the sources are switched off. In the dedicated-charger method, the DP current source starts first. The DM sink joins it late for a short window in which the DP-low flag is debounced. The detect flag rises when both are released. If no charger is seen, the block waits a long retry gap and runs the same handshake again. All intervals count a single timebase tick, so the chip's prescaler sets the real time.

Top module: `usb_chg_det_seq`

## Requirements
- R1: While reset is held, and after it while bus power is absent, all four outputs are low.
- R2: Bus power, after a two-flop synchronizer, must stay high for T_VBUS ticks before any enable rises; a drop before that restarts the debounce and no enable rises.
- R3: With method low (current sink), T_VDLY ticks after the debounce the DP voltage enable and the DM sink enable rise on the same clock and stay high for exactly T_SRC ticks, falling together.
- R4: In the current-sink window a charger is accepted only if the synchronized data-detect flag is high on every clock across T_CHG consecutive ticks; any low clock restarts this count.
- R5: After an accepted current-sink window, the detect output rises exactly T_HI ticks after the source enables fall and stays high while bus power lasts; while it is high no enable is on.
- R6: With method high (dedicated charger), the DP current-source enable is high for T_DCH + T_SINK ticks; the DM sink enable rises T_DCH ticks after it, falls with it, and the DP voltage enable stays low.
- R7: In the dedicated-charger sink window, a charger is accepted only if the synchronized DP-low flag stays high across T_CHG consecutive ticks; on acceptance detect rises on the clock the current source falls, otherwise detect stays low.
- R8: When a handshake ends without a charger, all outputs stay low for T_RETRY ticks, then the first phase of the same method starts again (for current sink: next DP voltage rise T_HI + T_RETRY + T_VDLY ticks after the previous fall).
- R9: When synchronized bus power drops, all outputs are low within three clocks and the sequencer returns to idle.
- R10: A filtered shutdown clears all outputs on the next clock and holds the sequencer idle until shutdown is released.
- R11: Shutdown, output-enable and method inputs are synchronized and take effect only after holding a new level for FILT_CYC consecutive clocks; shorter pulses have no effect.
- R12: With the filtered output-enable low, detect is forced low; the sequencer state is kept, so detect returns when output-enable comes back, with no new handshake.
- R13: The filtered method input is captured only when leaving idle (0 = current sink, 1 = dedicated charger); changing it mid-handshake or during retries has no effect until the next start from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase tick, one-clock pulse, advances all phase timers |
| vbus_ok_i | input | 1 | Bus-power comparator flag |
| dat_det_i | input | 1 | Data-line detect comparator flag |
| dp_low_i | input | 1 | DP-low comparator flag |
| shdn_i | input | 1 | Shutdown request, active high |
| out_en_i | input | 1 | Detect output enable, active high |
| method_i | input | 1 | Method select: 0 current sink, 1 dedicated charger |
| dp_vsrc_en_o | output | 1 | DP voltage source enable |
| dm_isink_en_o | output | 1 | DM current sink enable |
| dp_isrc_en_o | output | 1 | DP detection current source enable |
| detect_o | output | 1 | Charger detected flag |

## Verification
A wrong phase or timer value in this sequencer shows up as an enable edge a whole number of ticks away from its arithmetic position. The bench therefore stamps every rising and falling edge of the four outputs and compares the gaps with tick counts derived from the parameters. A lost or stuck acceptance flag shows within one handshake: detect rises when it should stay low, or a retry gap appears where detect was due. A bad abort path shows within three clocks of a power drop or a filtered shutdown, because the enables still follow their stale phase.

// File: rtl/usb_chg_pkg.sv
`timescale 1ns/1ps
package usb_chg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_VBUS_DB,
    ST_CS_DLY,
    ST_CS_SRC,
    ST_CS_HOLD,
    ST_DC_SRC,
    ST_DC_SINK,
    ST_RETRY,
    ST_FOUND
  } chg_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/chg_in_filter.sv
`timescale 1ns/1ps
// Synchronizer plus minimum-hold filter for a slow control pin.
module chg_in_filter #(
  parameter int unsigned HOLD_CYC = 100,
  parameter bit          RST_VAL  = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic lvl_o
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= {2{RST_VAL}};
      cnt_q  <= '0;
      lvl_q  <= RST_VAL;
    end else begin
      sync_q <= {sync_q[0], pin_i};
      if (sync_q[1] == lvl_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(HOLD_CYC - 1)) begin
        lvl_q <= sync_q[1];
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/chg_phase_timer.sv
`timescale 1ns/1ps
// Shared tick counter; restarts on every phase change.
module chg_phase_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic          tick_i,
  input  logic [CW-1:0] lim_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (tick_i)    cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = tick_i && (cnt_q == lim_i - CW'(1));
endmodule

// File: rtl/chg_run_check.sv
`timescale 1ns/1ps
// Continuous-high qualifier: level must hold across RUN_TICKS ticks.
module chg_run_check #(
  parameter int unsigned RUN_TICKS = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic keep_i,
  input  logic mon_i,
  input  logic lvl_i,
  input  logic tick_i,
  output logic ok_o
);
  localparam int unsigned CW = $clog2(RUN_TICKS + 1);

  logic [CW-1:0] run_q;
  logic          acc_q;
  logic          hit;

  assign hit  = mon_i && lvl_i && tick_i && !acc_q && (run_q == CW'(RUN_TICKS - 1));
  assign ok_o = acc_q | hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      acc_q <= 1'b0;
    end else if (!keep_i) begin
      run_q <= '0;
      acc_q <= 1'b0;
    end else if (!(mon_i && lvl_i)) begin
      run_q <= '0;
    end else if (hit) begin
      acc_q <= 1'b1;
    end else if (tick_i && !acc_q) begin
      run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/usb_chg_det_seq.sv
`timescale 1ns/1ps
module usb_chg_det_seq
  import usb_chg_pkg::*;
#(
  parameter int unsigned FILT_CYC = 100,
  parameter int unsigned T_VBUS   = 6,
  parameter int unsigned T_VDLY   = 6,
  parameter int unsigned T_SRC    = 120,
  parameter int unsigned T_CHG    = 25,
  parameter int unsigned T_HI     = 50,
  parameter int unsigned T_DCH    = 120,
  parameter int unsigned T_SINK   = 50,
  parameter int unsigned T_RETRY  = 11400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic vbus_ok_i,
  input  logic dat_det_i,
  input  logic dp_low_i,
  input  logic shdn_i,
  input  logic out_en_i,
  input  logic method_i,
  output logic dp_vsrc_en_o,
  output logic dm_isink_en_o,
  output logic dp_isrc_en_o,
  output logic detect_o
);
  localparam int unsigned TMAX = max_u(max_u(max_u(T_VBUS, T_VDLY), max_u(T_SRC, T_HI)),
                                       max_u(max_u(T_DCH, T_SINK), T_RETRY));
  localparam int unsigned CW     = $clog2(TMAX + 1);
  localparam int unsigned N_CTL  = 3;
  localparam logic [N_CTL-1:0] CTL_RST = 3'b010;  // {method, out_en, shdn}

  // control pins: filtered
  logic [N_CTL-1:0] ctl_pin, ctl_lvl;
  logic shdn_f, oe_f, meth_f;
  assign ctl_pin = {method_i, out_en_i, shdn_i};

  for (genvar g = 0; g < N_CTL; g++) begin : g_ctl
    chg_in_filter #(.HOLD_CYC(FILT_CYC), .RST_VAL(CTL_RST[g])) u_flt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pin_i (ctl_pin[g]),
      .lvl_o (ctl_lvl[g])
    );
  end
  assign shdn_f = ctl_lvl[0];
  assign oe_f   = ctl_lvl[1];
  assign meth_f = ctl_lvl[2];

  // comparator flags: synchronized only
  logic [2:0] af_s1, af_s2;
  logic vbus_s, dat_s, dplow_s;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      af_s1 <= '0;
      af_s2 <= '0;
    end else begin
      af_s1 <= {dp_low_i, dat_det_i, vbus_ok_i};
      af_s2 <= af_s1;
    end
  end
  assign vbus_s  = af_s2[0];
  assign dat_s   = af_s2[1];
  assign dplow_s = af_s2[2];

  chg_state_e    state_q, state_d;
  logic          meth_q;
  logic [CW-1:0] lim;
  logic          ph_done, restart, chg_ok;
  logic          mon, keep, mon_lvl;

  always_comb begin
    case (state_q)
      ST_VBUS_DB: lim = CW'(T_VBUS);
      ST_CS_DLY:  lim = CW'(T_VDLY);
      ST_CS_SRC:  lim = CW'(T_SRC);
      ST_CS_HOLD: lim = CW'(T_HI);
      ST_DC_SRC:  lim = CW'(T_DCH);
      ST_DC_SINK: lim = CW'(T_SINK);
      ST_RETRY:   lim = CW'(T_RETRY);
      default:    lim = '0;
    endcase
  end

  chg_phase_timer #(.CW(CW)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart),
    .tick_i   (tick_i),
    .lim_i    (lim),
    .done_o   (ph_done)
  );

  assign mon     = (state_q == ST_CS_SRC) || (state_q == ST_DC_SINK);
  assign keep    = mon || (state_q == ST_CS_HOLD);
  assign mon_lvl = (state_q == ST_CS_SRC) ? dat_s : dplow_s;

  chg_run_check #(.RUN_TICKS(T_CHG)) u_run (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .keep_i(keep),
    .mon_i (mon),
    .lvl_i (mon_lvl),
    .tick_i(tick_i),
    .ok_o  (chg_ok)
  );

  always_comb begin
    state_d = state_q;
    if (shdn_f || !vbus_s) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE:    state_d = ST_VBUS_DB;
        ST_VBUS_DB: if (ph_done) state_d = meth_q ? ST_DC_SRC : ST_CS_DLY;
        ST_CS_DLY:  if (ph_done) state_d = ST_CS_SRC;
        ST_CS_SRC:  if (ph_done) state_d = ST_CS_HOLD;
        ST_CS_HOLD: if (ph_done) state_d = chg_ok ? ST_FOUND : ST_RETRY;
        ST_DC_SRC:  if (ph_done) state_d = ST_DC_SINK;
        ST_DC_SINK: if (ph_done) state_d = chg_ok ? ST_FOUND : ST_RETRY;
        ST_RETRY:   if (ph_done) state_d = meth_q ? ST_DC_SRC : ST_CS_DLY;
        ST_FOUND:   state_d = ST_FOUND;
        default:    state_d = ST_IDLE;
      endcase
    end
  end
  assign restart = (state_d != state_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      meth_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && state_d == ST_VBUS_DB) meth_q <= meth_f;
    end
  end

  assign dp_vsrc_en_o  = (state_q == ST_CS_SRC);
  assign dm_isink_en_o = (state_q == ST_CS_SRC) || (state_q == ST_DC_SINK);
  assign dp_isrc_en_o  = (state_q == ST_DC_SRC) || (state_q == ST_DC_SINK);
  assign detect_o      = (state_q == ST_FOUND) && oe_f;
endmodule

// File: rtl/usb_chg_det_seq_chk.sv
`timescale 1ns/1ps
module usb_chg_det_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic vbus_s,
  input logic shdn_f,
  input logic dp_vsrc_en_o,
  input logic dm_isink_en_o,
  input logic dp_isrc_en_o,
  input logic detect_o
);
  logic any_en;
  assign any_en = dp_vsrc_en_o || dm_isink_en_o || dp_isrc_en_o;

  assert_src_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dp_vsrc_en_o && dp_isrc_en_o));

  assert_sink_needs_src_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dm_isink_en_o |-> (dp_vsrc_en_o || dp_isrc_en_o));

  assert_cs_pair_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dp_vsrc_en_o) |-> $rose(dm_isink_en_o));

  assert_dc_sink_late_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dp_isrc_en_o) |-> !dm_isink_en_o);

  assert_detect_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    detect_o |-> !any_en);

  assert_vbus_loss_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vbus_s |=> !(any_en || detect_o));

  assert_shdn_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shdn_f |=> !(any_en || detect_o));
endmodule

bind usb_chg_det_seq usb_chg_det_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .vbus_s       (vbus_s),
  .shdn_f       (shdn_f),
  .dp_vsrc_en_o (dp_vsrc_en_o),
  .dm_isink_en_o(dm_isink_en_o),
  .dp_isrc_en_o (dp_isrc_en_o),
  .detect_o     (detect_o)
);

// File: tb/usb_chg_det_seq_test.sv
`timescale 1ns/1ps
module usb_chg_det_seq_test;
  localparam int TP      = 3;
  localparam int FILT    = 4;
  localparam int T_VBUS  = 3;
  localparam int T_VDLY  = 2;
  localparam int T_SRC   = 8;
  localparam int T_CHG   = 3;
  localparam int T_HI    = 4;
  localparam int T_DCH   = 6;
  localparam int T_SINK  = 5;
  localparam int T_RETRY = 10;

  logic clk = 1'b0;
  logic rst_n, tick, vbus, dat, dplow, shdn, oe, meth;
  logic vsrc, sink, isrc, det;
  logic [3:0] outs;
  int   dat_mode;
  int   total = 0, bad = 0, cyc = 0;
  int   rise_at [4];
  int   fall_at [4];
  logic [3:0] prev = '0;

  always #10 clk = ~clk;

  usb_chg_det_seq #(
    .FILT_CYC(FILT), .T_VBUS(T_VBUS), .T_VDLY(T_VDLY), .T_SRC(T_SRC), .T_CHG(T_CHG),
    .T_HI(T_HI), .T_DCH(T_DCH), .T_SINK(T_SINK), .T_RETRY(T_RETRY)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .vbus_ok_i(vbus), .dat_det_i(dat),
    .dp_low_i(dplow), .shdn_i(shdn), .out_en_i(oe), .method_i(meth),
    .dp_vsrc_en_o(vsrc), .dm_isink_en_o(sink), .dp_isrc_en_o(isrc), .detect_o(det)
  );

  assign outs = {det, isrc, sink, vsrc};

  // edge stamps: 0 vsrc, 1 sink, 2 isrc, 3 detect
  always @(negedge clk) begin
    cyc = cyc + 1;
    for (int i = 0; i < 4; i++) begin
      if (outs[i] && !prev[i]) rise_at[i] = cyc;
      if (!outs[i] && prev[i]) fall_at[i] = cyc;
    end
    prev = outs;
  end

  initial begin
    int tc;
    tc = 0;
    tick = 1'b0;
    forever begin
      @(negedge clk);
      tick = (tc == TP - 1);
      tc = (tc + 1) % TP;
    end
  end

  initial begin
    int gc;
    gc = 0;
    dat = 1'b0;
    forever begin
      @(negedge clk);
      case (dat_mode)
        0: dat = 1'b0;
        1: dat = 1'b1;
        default: dat = (gc % 6 != 0);
      endcase
      gc = gc + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic clr();
    for (int i = 0; i < 4; i++) begin
      rise_at[i] = -1;
      fall_at[i] = -1;
    end
  endtask

  task automatic wait_lvl(input int idx, input logic lvl);
    int n;
    n = 0;
    while (outs[idx] !== lvl && n < 3000) begin
      @(negedge clk);
      n++;
    end
    #1;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int t0, f1;
    rst_n = 1'b0; vbus = 1'b0; dat_mode = 1; dplow = 1'b0;
    shdn = 1'b0; oe = 1'b1; meth = 1'b0;
    clr();
    cycles(5);
    chk("R1 outputs in reset", int'(outs), 0);
    rst_n = 1'b1;
    cycles(10);
    chk("R1 idle without power", int'(outs), 0);

    // R2: short power pulse does not pass debounce
    clr();
    vbus = 1'b1; cycles(4); vbus = 1'b0;
    cycles(60);
    chk("R2 short power no vsrc", rise_at[0], -1);
    chk("R2 short power no isrc", rise_at[2], -1);

    // R3/R5: current sink, steady data detect
    clr();
    t0 = cyc;
    vbus = 1'b1;
    wait_lvl(0, 1'b1);
    chk_rng("R2 attach to vsrc", rise_at[0] - t0, (T_VBUS + T_VDLY - 1) * TP + 2, (T_VBUS + T_VDLY) * TP + 4);
    chk("R3 sink rises with vsrc", rise_at[1], rise_at[0]);
    wait_lvl(0, 1'b0);
    chk("R3 vsrc width", fall_at[0] - rise_at[0], T_SRC * TP);
    chk("R3 sink falls with vsrc", fall_at[1], fall_at[0]);
    wait_lvl(3, 1'b1);
    chk("R5 vsrc fall to detect", rise_at[3] - fall_at[0], T_HI * TP);
    cycles(30);
    chk("R5 detect held", int'(det), 1);

    // R11/R12: output enable
    oe = 1'b0; cycles(FILT - 1); oe = 1'b1;
    cycles(12);
    chk("R11 short oe pulse ignored", int'(det), 1);
    oe = 1'b0; cycles(FILT + 4);
    chk("R12 oe low forces detect low", int'(det), 0);
    clr();
    oe = 1'b1; cycles(FILT + 4);
    chk("R12 detect returns", int'(det), 1);
    chk("R12 no new handshake", rise_at[0], -1);

    // R11: short shutdown ignored
    shdn = 1'b1; cycles(FILT - 1); shdn = 1'b0;
    cycles(12);
    chk("R11 short shdn ignored", int'(det), 1);

    // R9: power loss
    vbus = 1'b0; cycles(3);
    chk("R9 outputs clear after loss", int'(outs), 0);
    cycles(10);

    // R4/R8: broken data detect, then retry with steady level
    dat_mode = 2;
    clr();
    vbus = 1'b1;
    wait_lvl(0, 1'b1);
    wait_lvl(0, 1'b0);
    dat_mode = 1;
    f1 = fall_at[0];
    wait_lvl(0, 1'b1);
    chk("R8 cs retry gap", rise_at[0] - f1, (T_HI + T_RETRY + T_VDLY) * TP);
    chk("R4 glitched level rejected", rise_at[3], -1);
    wait_lvl(0, 1'b0);
    wait_lvl(3, 1'b1);
    chk("R4 steady level accepted", rise_at[3] - fall_at[0], T_HI * TP);
    vbus = 1'b0; dat_mode = 0;
    cycles(10);

    // R6/R7: dedicated charger, accepted
    meth = 1'b1; cycles(FILT + 4);
    dplow = 1'b1;
    clr();
    vbus = 1'b1;
    wait_lvl(2, 1'b1);
    wait_lvl(1, 1'b1);
    chk("R6 isrc to sink delay", rise_at[1] - rise_at[2], T_DCH * TP);
    chk("R6 vsrc unused", rise_at[0], -1);
    wait_lvl(2, 1'b0);
    chk("R6 sink window", fall_at[2] - rise_at[1], T_SINK * TP);
    chk("R6 sink falls with isrc", fall_at[1], fall_at[2]);
    wait_lvl(3, 1'b1);
    chk("R7 detect at isrc fall", rise_at[3], fall_at[2]);
    vbus = 1'b0;
    cycles(10);

    // R7/R8/R13: dedicated charger rejected, method changed mid-run
    dplow = 1'b0;
    clr();
    vbus = 1'b1;
    wait_lvl(2, 1'b1);
    meth = 1'b0;
    wait_lvl(1, 1'b1);
    wait_lvl(2, 1'b0);
    f1 = fall_at[2];
    wait_lvl(2, 1'b1);
    chk("R8 dc retry gap", rise_at[2] - f1, T_RETRY * TP);
    chk("R7 no dp low rejected", rise_at[3], -1);
    chk("R13 method kept mid run", rise_at[0], -1);
    vbus = 1'b0; cycles(3);
    chk("R9 loss with isrc on", int'(outs), 0);
    cycles(10);

    // R10/R13: shutdown during current-sink run
    vbus = 1'b1;
    wait_lvl(0, 1'b1);
    chk("R13 new method after idle", int'(vsrc), 1);
    shdn = 1'b1; cycles(FILT + 3);
    chk("R10 shdn clears outputs", int'(outs), 0);
    clr();
    cycles(100);
    chk("R10 held idle vsrc", rise_at[0], -1);
    chk("R10 held idle isrc", rise_at[2], -1);
    shdn = 1'b0;
    wait_lvl(0, 1'b1);
    chk("R10 restart after release", int'(vsrc), 1);

    finish_run();
  end
endmodule